// File: doc/BRIEF.md
# Maskable Interrupt In-Service Tracker

This block records which maskable interrupt priority levels a CPU is servicing, and it decides when a pending maskable request may be acknowledged. It keeps an 8-bit in-service vector with one bit per priority level. Level 0 is the most urgent and level 7 the least. A global disable flag gates maskable acknowledgement. The CPU core drives single-cycle strobes for its disable, enable, return-from-interrupt and status-word-write operations. A request source holds its request and priority level until it sees the acknowledge pulse.

A maskable request is granted only when the disable flag is clear and its level outranks every level already in service. A grant sets the level's in-service bit and sets the disable flag. Non-maskable and exception requests are acknowledged whatever the flag says, and they win over a maskable request in the same cycle. A return from a maskable handler clears the most urgent in-service bit. A return from a non-maskable or exception handler leaves the vector unchanged.

Top module: `isr_tracker`

## Requirements
- R1: After reset the in-service vector `in_service` is 0x00, `irq_off` is 1, and neither acknowledge output is high.
- R2: When `mreq` is high, `irq_off` is 0 and no `xreq` is present, the next clock edge raises `mack` with `mack_lvl` equal to `mreq_lvl`. At that same edge, bit `mreq_lvl` of `in_service` is set and stays set until a return clears it.
- R3: A maskable acknowledge sets `irq_off` to 1 at the edge that raises `mack`.
- R4: A maskable request held while `irq_off` is 1 is not acknowledged. Once an enable strobe clears the flag, it is acknowledged at the following edge if still held.
- R5: A maskable request is not acknowledged when any `in_service` bit at an index equal to or lower than its level is set.
- R6: A `ret_stb` pulse with `ret_special` low clears only the lowest-indexed set bit of `in_service`. Every return pulse loads `irq_off` from `ret_off`.
- R7: A `ret_stb` pulse with `ret_special` high leaves `in_service` unchanged.
- R8: `di_stb` sets `irq_off` and `ei_stb` clears it. `psw_wr` loads it from `psw_off`. When strobes coincide, the order of precedence is acknowledge, then status write, then return, then disable, then enable.
- R9: `xreq` raises `xack` at the next edge whatever the value of `irq_off`. It blocks a maskable grant in that cycle and changes neither `in_service` nor `irq_off`.
- R10: When a normal return and a maskable request fall in the same cycle, the clear is applied first. The grant test uses the cleared vector.
- R11: `mack` and `xack` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreq | input | 1 | Maskable request pending |
| mreq_lvl | input | 3 | Priority level of the pending request (0 most urgent) |
| xreq | input | 1 | Non-maskable or exception request |
| di_stb | input | 1 | Disable strobe |
| ei_stb | input | 1 | Enable strobe |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| ret_special | input | 1 | Return is from non-maskable or exception servicing |
| ret_off | input | 1 | Disable-flag value restored by the return |
| psw_wr | input | 1 | Status word write strobe |
| psw_off | input | 1 | Disable-flag value carried by the write |
| mack | output | 1 | Maskable acknowledge pulse |
| mack_lvl | output | 3 | Level granted with `mack` |
| xack | output | 1 | Non-maskable acknowledge pulse |
| in_service | output | 8 | Read-only in-service vector |
| irq_off | output | 1 | Current disable flag |

## Verification
Requests are raised while the flag is set, at a level equal to one in service, at a less urgent level, and at a more urgent level. Each case on its own separates the flag gate from the priority comparison and exposes an off-by-one in the mask. Requests at levels 3, 1 and 0 build up a nested stack. Returns then unwind it, which shows that only the most urgent bit is cleared. A non-maskable request that coincides with a maskable one, and returns that coincide with requests, show the precedence between them and that the clear comes before the grant test.

// File: rtl/isr_tracker.sv
module isr_tracker #(
  parameter int LEVELS = 8,
  localparam int LW = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mreq,
  input  logic [LW-1:0] mreq_lvl,
  input  logic          xreq,
  input  logic          di_stb,
  input  logic          ei_stb,
  input  logic          ret_stb,
  input  logic          ret_special,
  input  logic          ret_off,
  input  logic          psw_wr,
  input  logic          psw_off,
  output logic          mack,
  output logic [LW-1:0] mack_lvl,
  output logic          xack,
  output logic [LEVELS-1:0] in_service,
  output logic          irq_off
);

  logic [LEVELS-1:0] top_bit, after_ret, upto_mask;
  logic [LEVELS:0]   wide_mask;
  logic              grant;

  assign top_bit   = in_service & (~in_service + 1'b1);
  assign after_ret = (ret_stb && !ret_special) ? (in_service & ~top_bit) : in_service;
  assign wide_mask = ({{LEVELS{1'b0}}, 1'b1} << ({1'b0, mreq_lvl} + 1'b1)) - 1'b1;
  assign upto_mask = wide_mask[LEVELS-1:0];
  assign grant     = mreq && !irq_off && !xreq && ((after_ret & upto_mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_service <= '0;
      irq_off    <= 1'b1;
      mack       <= 1'b0;
      mack_lvl   <= '0;
      xack       <= 1'b0;
    end else begin
      mack <= grant;
      xack <= xreq;
      if (grant) mack_lvl <= mreq_lvl;
      in_service <= grant ? (after_ret | (LEVELS'(1) << mreq_lvl)) : after_ret;
      if (grant)        irq_off <= 1'b1;
      else if (psw_wr)  irq_off <= psw_off;
      else if (ret_stb) irq_off <= ret_off;
      else if (di_stb)  irq_off <= 1'b1;
      else if (ei_stb)  irq_off <= 1'b0;
    end
  end

  assert_mack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mack |=> !mack);
  assert_mack_sets_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mack |-> irq_off);
  assert_mack_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mack |-> in_service[mack_lvl]);
  assert_x_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xack |-> !mack);
  assert_special_ret_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb && ret_special) |=> (mack || in_service == $past(in_service)));

endmodule

// File: tb/isr_tracker_test.sv
module isr_tracker_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mreq = 0, xreq = 0, di_stb = 0, ei_stb = 0, ret_stb = 0, ret_special = 0;
  logic ret_off = 0, psw_wr = 0, psw_off = 0;
  logic [2:0] mreq_lvl = 0;
  logic mack, xack, irq_off;
  logic [2:0] mack_lvl;
  logic [7:0] in_service;
  int checks = 0, failures = 0;
  logic [2:0] expq[$];
  bit done = 0;

  always #2 clk = ~clk;

  isr_tracker uut (.clk, .rst_n, .mreq, .mreq_lvl, .xreq, .di_stb, .ei_stb, .ret_stb,
    .ret_special, .ret_off, .psw_wr, .psw_off, .mack, .mack_lvl, .xack, .in_service, .irq_off);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic pulses_off();
    xreq = 0; di_stb = 0; ei_stb = 0; ret_stb = 0; ret_special = 0; psw_wr = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mack) begin
      if (expq.size() == 0) chk(0, "R2 unexpected ack", mack_lvl, 0);
      else begin
        logic [2:0] e;
        e = expq.pop_front();
        chk(mack_lvl == e, "R2 ack level", mack_lvl, e);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    chk(in_service == 0 && irq_off && !mack && !xack, "R1 reset", {in_service, irq_off}, 1);

    mreq = 1; mreq_lvl = 3;
    repeat (3) step();
    chk(in_service == 0, "R4 held while off", in_service, 0);
    expq.push_back(3);
    ei_stb = 1; step(); pulses_off(); step();
    mreq = 0;
    chk(mack == 1, "R4 ack after enable", mack, 1);
    chk(in_service == 8'h08, "R2 bit set", in_service, 8'h08);
    chk(irq_off == 1, "R3 flag set", irq_off, 1);
    step();
    chk(mack == 0, "R11 single pulse", mack, 0);

    ei_stb = 1; step(); pulses_off();
    mreq = 1; mreq_lvl = 5; repeat (3) step();
    chk(in_service == 8'h08 && !irq_off, "R5 less urgent blocked", in_service, 8'h08);
    mreq_lvl = 3; repeat (3) step();
    chk(in_service == 8'h08, "R5 equal level blocked", in_service, 8'h08);
    mreq_lvl = 1; expq.push_back(1); step(); mreq = 0;
    chk(mack && in_service == 8'h0A && irq_off, "R2 nested ack", in_service, 8'h0A);

    ei_stb = 1; step(); pulses_off();
    expq.push_back(0);
    xreq = 1; mreq = 1; mreq_lvl = 0; step();
    chk(xack && !mack, "R9 exception wins", {xack, mack}, 2);
    chk(in_service == 8'h0A && !irq_off, "R9 no state change", {in_service, irq_off}, 8'h14);
    xreq = 0; step(); mreq = 0;
    chk(xack == 0, "R11 xack single pulse", xack, 0);
    chk(in_service == 8'h0B, "R2 level0 ack", in_service, 8'h0B);
    xreq = 1; step(); xreq = 0;
    chk(xack == 1 && irq_off, "R9 ack while off", xack, 1);

    ret_stb = 1; ret_special = 1; ret_off = 1; step(); pulses_off();
    chk(in_service == 8'h0B, "R7 special return", in_service, 8'h0B);
    ret_stb = 1; ret_off = 1; step(); pulses_off();
    chk(in_service == 8'h0A && irq_off, "R6 clear top", in_service, 8'h0A);
    ret_stb = 1; ret_off = 0; step(); pulses_off();
    chk(in_service == 8'h08 && !irq_off, "R6 clear next, load flag", {in_service, irq_off}, 8'h10);

    di_stb = 1; step(); pulses_off();
    chk(irq_off == 1, "R8 disable", irq_off, 1);
    ei_stb = 1; step(); pulses_off();
    chk(irq_off == 0, "R8 enable", irq_off, 0);
    psw_wr = 1; psw_off = 1; ei_stb = 1; step(); pulses_off();
    chk(irq_off == 1, "R8 write beats enable", irq_off, 1);
    psw_wr = 1; psw_off = 0; di_stb = 1; step(); pulses_off();
    chk(irq_off == 0, "R8 write beats disable", irq_off, 0);

    ret_stb = 1; ret_special = 1; ret_off = 0; mreq = 1; mreq_lvl = 3; step(); pulses_off(); mreq = 0;
    chk(!mack && in_service == 8'h08, "R10 special return no clear", in_service, 8'h08);
    expq.push_back(3);
    ret_stb = 1; ret_off = 0; mreq = 1; mreq_lvl = 3; step(); pulses_off(); mreq = 0;
    chk(mack && in_service == 8'h08 && irq_off, "R10 clear before grant", {mack, in_service}, 9'h108);

    step(); step();
    chk(expq.size() == 0, "R2 all acks seen", expq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule